// File: doc/BRIEF.md
# Multibank Burst Command Sequencer

The sequencer turns a stream of read and write requests into a command stream for a banked memory device. It issues one command per clock. Each request names a bank, a row, a column and a direction, and can ask for the row to be closed automatically when its burst ends. The block remembers which row is open in every bank. A request to the open row goes straight to a column command. A request to a closed bank is preceded by an ACTIVATE. A request to a different row first closes the bank with a PRECHARGE and then opens the new row. Activate-to-column and precharge-to-activate delays are counted in clocks for each bank separately. This lets one bank be opened or closed while another bank is still bursting.

The burst length is four or eight beats, chosen by a configuration input and latched with each column command. A burst of eight can be cut short by a column command of the same direction two clocks after the first one. A column command of the other direction waits for the whole burst. A refresh request stops new requests from being accepted, finishes the request in hand, closes every open bank and then raises an acknowledge.

Top module: `bank_cmd_seq`

## Requirements
- R1: After reset the command bus carries NOP (ras_n, cas_n, we_n = 111), req_ready is high and ref_ack is low.
- R2: A request to a closed bank issues ACTIVATE (011) with the bank on cmd_bank and the row on cmd_addr. The READ (101) or WRITE (100) follows exactly TRCD clocks later. Its cmd_addr carries the column in bits [9:0] and the auto-close flag in bit 10.
- R3: A request to the row already open in its bank issues only the column command, with no ACTIVATE or PRECHARGE.
- R4: A request to a different row of an open bank issues PRECHARGE (010, addr bit 10 = 0) to that bank, then ACTIVATE exactly TRP clocks later, then the column command exactly TRCD clocks after that. The PRECHARGE is not issued before the burst running in that bank has ended, which is BL/2 clocks after its column command.
- R5: cfg_bl8 = 1 selects bursts of eight beats (four clocks) and 0 selects four beats (two clocks). A column command of the opposite direction follows the previous one no sooner than BL/2 clocks.
- R6: A column command of the same direction follows the previous one exactly two clocks later when it is ready. For a burst of eight this cuts the burst short. A burst of either length is never cut before two clocks.
- R7: A column command with auto-close sets addr bit 10, and no PRECHARGE is issued for it. The bank is then closed. The next access to it begins with ACTIVATE, no sooner than BL/2 + TRP clocks after the column command.
- R8: An ACTIVATE to another bank may be issued in the clock right after a column command, while that burst is still running.
- R9: The command codes on {ras_n, cas_n, we_n} are ACTIVATE 011, READ 101, WRITE 100, PRECHARGE 010 and NOP 111, with at most one command per clock.
- R10: While ref_req is high, req_ready is low. Open banks are closed by one PRECHARGE with addr bit 10 = 1. ref_ack rises exactly TRP clocks after that PRECHARGE, or without any command if no bank is open. It stays high until ref_req falls. Afterwards every bank is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bl8 | input | 1 | 1 = burst of eight, 0 = burst of four |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Close the row when the burst ends |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Starting column |
| ref_req | input | 1 | Refresh wanted; all banks must be closed |
| ref_ack | output | 1 | All banks closed and idle for refresh |
| cmd_ras_n | output | 1 | Command code bit 2 |
| cmd_cas_n | output | 1 | Command code bit 1 |
| cmd_we_n | output | 1 | Command code bit 0 |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_addr | output | ADDR_W | Row, or column with auto-close at bit 10, or all-bank flag at bit 10 |

## Verification
Each scenario uses a different request pattern so that the distance between logged commands identifies one rule. A closed bank checks the activate-to-column delay. An open row checks that no ACTIVATE is issued. A row conflict separates precharge waiting on the burst from the precharge-to-activate delay. Read-read, read-write and write-write pairs under both burst lengths separate the two-clock interrupt from the full-burst wait. An auto-close write followed by a second access to the same bank shows the self-timed close: ACTIVATE without PRECHARGE, spaced by burst plus TRP. A request to a second bank right behind a burst shows banks working side by side. Refresh is tried with banks open and with all banks closed, to tell the precharge-all path from the direct acknowledge.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [2:0] {
    OP_ACT = 3'b011,
    OP_RD  = 3'b101,
    OP_WR  = 3'b100,
    OP_PRE = 3'b010,
    OP_NOP = 3'b111
  } dram_op_e;

  // clocks occupied on the data bus by one burst
  localparam int BL8_CLKS = 4;
  localparam int BL4_CLKS = 2;
  // earliest same-direction interrupt, in clocks after the first command
  localparam int INTR_CLKS = 2;
  // address bit carrying the auto-close / all-bank flag
  localparam int FLAG_BIT = 10;
endpackage

// File: rtl/bank_tracker.sv
module bank_tracker
  import bcs_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int TRCD  = 3,
  parameter int TRP   = 2,
  parameter int TW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             col_i,
  input  logic             ap_i,
  input  logic             bl8_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             idle_o
);
  logic [TW-1:0]    tmr_q;
  logic             open_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_q  <= '0;
      open_q <= 1'b0;
      row_q  <= '0;
    end else begin
      if (act_i) begin
        open_q <= 1'b1;
        row_q  <= row_i;
        tmr_q  <= TW'(TRCD - 1);
      end else if (pre_i) begin
        open_q <= 1'b0;
        tmr_q  <= TW'(TRP - 1);
      end else if (col_i && ap_i) begin
        open_q <= 1'b0;
        tmr_q  <= bl8_i ? TW'(BL8_CLKS + TRP - 1) : TW'(BL4_CLKS + TRP - 1);
      end else if (tmr_q != '0) begin
        tmr_q <= tmr_q - 1'b1;
      end
    end
  end

  assign open_o = open_q;
  assign row_o  = row_q;
  assign idle_o = (tmr_q == '0);

  AST_ACT_CLOSED: assert property (@(posedge clk) disable iff (rst)
    act_i |-> (!open_q && tmr_q == '0)); // R2
  AST_COL_OPEN: assert property (@(posedge clk) disable iff (rst)
    col_i |-> (open_q && tmr_q == '0 && row_i == row_q)); // R3
  AST_PRE_TIMED: assert property (@(posedge clk) disable iff (rst)
    pre_i |-> (tmr_q == '0)); // R4
endmodule

// File: rtl/burst_ctl.sv
module burst_ctl
  import bcs_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              col_i,
  input  logic              wr_i,
  input  logic              ap_i,
  input  logic              bl8_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              q_wr_i,
  output logic              ok_o,
  output logic              busy_o,
  output logic [BANK_W-1:0] bank_o
);
  localparam int BW = $clog2(BL8_CLKS + 1);

  logic [BW-1:0]     left_q;
  logic              wr_q, ap_q, bl8_q;
  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      wr_q   <= 1'b0;
      ap_q   <= 1'b0;
      bl8_q  <= 1'b0;
      bank_q <= '0;
    end else if (col_i) begin
      left_q <= bl8_i ? BW'(BL8_CLKS - 1) : BW'(BL4_CLKS - 1);
      wr_q   <= wr_i;
      ap_q   <= ap_i;
      bl8_q  <= bl8_i;
      bank_q <= bank_i;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  logic may_cut;
  assign may_cut = (q_wr_i == wr_q) && bl8_q && !ap_q &&
                   (left_q <= BW'(BL8_CLKS - INTR_CLKS));
  assign ok_o   = (left_q == '0) || may_cut;
  assign busy_o = (left_q != '0);
  assign bank_o = bank_q;

  AST_INTR_RULE: assert property (@(posedge clk) disable iff (rst)
    (col_i && left_q != '0) |-> (wr_i == wr_q && bl8_q && !ap_q)); // R6
endmodule

// File: rtl/bank_cmd_seq.sv
module bank_cmd_seq
  import bcs_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int ADDR_W    = 14,
  parameter int TRCD      = 3,
  parameter int TRP       = 2,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_bl8,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_autopre,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              ref_req,
  output logic              ref_ack,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr
);
  localparam int TW = $clog2(BL8_CLKS + TRCD + TRP + 1);

  // held request
  logic              hv;
  logic              h_wr, h_ap;
  logic [BANK_W-1:0] h_bank;
  logic [ROW_W-1:0]  h_row;
  logic [COL_W-1:0]  h_col;

  // per-bank state
  logic [NUM_BANKS-1:0] b_open, b_idle, b_act, b_pre, b_col;
  logic [ROW_W-1:0]     b_row [NUM_BANKS];

  logic              col_ok, burst_busy;
  logic [BANK_W-1:0] burst_bank;

  logic tgt_open, tgt_hit, tgt_idle;
  logic do_act, do_pre, do_col, do_prea, ack_next;

  function automatic logic [ADDR_W-1:0] col_addr(input logic [COL_W-1:0] c,
                                                 input logic flag);
    logic [ADDR_W-1:0] a;
    a = '0;
    for (int i = 0; i < COL_W; i++) begin
      if (i < FLAG_BIT) a[i] = c[i];
      else              a[i+1] = c[i];
    end
    a[FLAG_BIT] = flag;
    return a;
  endfunction

  genvar gb;
  generate
    for (gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
      assign b_act[gb] = do_act && (h_bank == BANK_W'(gb));
      assign b_pre[gb] = (do_pre && (h_bank == BANK_W'(gb))) || do_prea;
      assign b_col[gb] = do_col && (h_bank == BANK_W'(gb));

      bank_tracker #(
        .ROW_W(ROW_W), .TRCD(TRCD), .TRP(TRP), .TW(TW)
      ) u_trk (
        .clk    (clk),
        .rst    (rst),
        .act_i  (b_act[gb]),
        .pre_i  (b_pre[gb]),
        .col_i  (b_col[gb]),
        .ap_i   (h_ap),
        .bl8_i  (cfg_bl8),
        .row_i  (h_row),
        .open_o (b_open[gb]),
        .row_o  (b_row[gb]),
        .idle_o (b_idle[gb])
      );
    end
  endgenerate

  burst_ctl #(.BANK_W(BANK_W)) u_burst (
    .clk    (clk),
    .rst    (rst),
    .col_i  (do_col),
    .wr_i   (h_wr),
    .ap_i   (h_ap),
    .bl8_i  (cfg_bl8),
    .bank_i (h_bank),
    .q_wr_i (h_wr),
    .ok_o   (col_ok),
    .busy_o (burst_busy),
    .bank_o (burst_bank)
  );

  // decision for the held request, or for a pending refresh
  always_comb begin
    tgt_open = b_open[h_bank];
    tgt_hit  = tgt_open && (b_row[h_bank] == h_row);
    tgt_idle = b_idle[h_bank];
    do_col   = hv && tgt_hit && tgt_idle && col_ok;
    do_pre   = hv && tgt_open && !tgt_hit && tgt_idle &&
               !(burst_busy && burst_bank == h_bank);
    do_act   = hv && !tgt_open && tgt_idle;
    do_prea  = !hv && ref_req && (|b_open) && (&b_idle) && !burst_busy;
    ack_next = !hv && ref_req && !(|b_open) && (&b_idle);
  end

  assign req_ready = (!hv || do_col) && !ref_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      hv     <= 1'b0;
      h_wr   <= 1'b0;
      h_ap   <= 1'b0;
      h_bank <= '0;
      h_row  <= '0;
      h_col  <= '0;
    end else if (req_valid && req_ready) begin
      hv     <= 1'b1;
      h_wr   <= req_write;
      h_ap   <= req_autopre;
      h_bank <= req_bank;
      h_row  <= req_row;
      h_col  <= req_col;
    end else if (do_col) begin
      hv <= 1'b0;
    end
  end

  // registered command bus
  dram_op_e          op_q;
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] addr_q;
  logic              ack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_NOP;
      bank_q <= '0;
      addr_q <= '0;
      ack_q  <= 1'b0;
    end else begin
      ack_q  <= ack_next;
      bank_q <= h_bank;
      addr_q <= '0;
      if (do_act) begin
        op_q   <= OP_ACT;
        addr_q <= ADDR_W'(h_row);
      end else if (do_pre) begin
        op_q <= OP_PRE;
      end else if (do_col) begin
        op_q   <= h_wr ? OP_WR : OP_RD;
        addr_q <= col_addr(h_col, h_ap);
      end else if (do_prea) begin
        op_q   <= OP_PRE;
        bank_q <= '0;
        addr_q[FLAG_BIT] <= 1'b1;
      end else begin
        op_q <= OP_NOP;
      end
    end
  end

  assign cmd_ras_n = op_q[2];
  assign cmd_cas_n = op_q[1];
  assign cmd_we_n  = op_q[0];
  assign cmd_bank  = bank_q;
  assign cmd_addr  = addr_q;
  assign ref_ack   = ack_q;

  AST_REF_STALL: assert property (@(posedge clk) disable iff (rst)
    (ref_req && !hv) |=> !hv); // R10
  AST_ACK_CLOSED: assert property (@(posedge clk) disable iff (rst)
    ref_ack |-> (b_open == '0)); // R10
  AST_ONE_CMD: assert property (@(posedge clk) disable iff (rst)
    $onehot0({b_act != '0, do_pre, b_col != '0, do_prea})); // R9
endmodule

// File: tb/sim_bank_cmd_seq.sv
`timescale 1ns/1ps
module sim_bank_cmd_seq;
  localparam int TRCD = 3;
  localparam int TRP  = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_bl8 = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_autopre = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [12:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic        ref_req = 1'b0;
  logic        req_ready, ref_ack;
  logic        ras_n, cas_n, we_n;
  logic [1:0]  cmd_bank;
  logic [13:0] cmd_addr;

  always #4 clk = ~clk;

  bank_cmd_seq #(.TRCD(TRCD), .TRP(TRP)) u0 (
    .clk(clk), .rst(rst), .cfg_bl8(cfg_bl8),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_autopre(req_autopre), .req_bank(req_bank), .req_row(req_row),
    .req_col(req_col), .ref_req(ref_req), .ref_ack(ref_ack),
    .cmd_ras_n(ras_n), .cmd_cas_n(cas_n), .cmd_we_n(we_n),
    .cmd_bank(cmd_bank), .cmd_addr(cmd_addr)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  bit done = 0;

  // command log
  int         n_log = 0;
  int         l_cyc  [64];
  logic [2:0] l_cmd  [64];
  logic [1:0] l_bank [64];
  logic [13:0] l_addr[64];
  int  ack_cyc = -1;
  logic ack_prev = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && {ras_n, cas_n, we_n} != 3'b111 && n_log < 64) begin
      l_cyc[n_log]  = cyc;
      l_cmd[n_log]  = {ras_n, cas_n, we_n};
      l_bank[n_log] = cmd_bank;
      l_addr[n_log] = cmd_addr;
      n_log++;
    end
    if (!rst && ref_ack && !ack_prev) ack_cyc = cyc;
    ack_prev = ref_ack;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] b, input logic [12:0] r, input logic [9:0] c,
                      input logic wr, input logic ap);
    @(negedge clk);
    req_valid = 1'b1; req_bank = b; req_row = r; req_col = c;
    req_write = wr; req_autopre = ap;
    #1;
    for (int k = 0; k < 100 && !req_ready; k++) begin
      @(negedge clk); #1;
    end
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk({ras_n, cas_n, we_n} == 3'b111, "R1 cmd", {ras_n, cas_n, we_n}, 7);
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(ref_ack == 1'b0, "R1 ack", ref_ack, 0);
  endtask

  task automatic t_miss;
    n_log = 0;
    send(0, 13'd5, 10'd8, 1'b0, 1'b0);
    idle(12);
    chk(n_log == 2, "R2 count", n_log, 2);
    chk(l_cmd[0] == 3'b011 && l_bank[0] == 0, "R2 act code", l_cmd[0], 3);
    chk(l_addr[0] == 14'd5, "R2 row addr", l_addr[0], 5);
    chk(l_cmd[1] == 3'b101, "R9 read code", l_cmd[1], 5);
    chk(l_addr[1] == 14'd8, "R2 col addr", l_addr[1], 8);
    chk(l_cyc[1] - l_cyc[0] == TRCD, "R2 trcd gap", l_cyc[1] - l_cyc[0], TRCD);
  endtask

  task automatic t_hit_intr;
    n_log = 0;
    send(0, 13'd5, 10'd16, 1'b0, 1'b0);
    send(0, 13'd5, 10'd24, 1'b0, 1'b0);
    send(0, 13'd5, 10'd32, 1'b1, 1'b0);
    idle(12);
    chk(n_log == 3, "R3 no activate", n_log, 3);
    chk(l_cmd[0] == 3'b101 && l_addr[0] == 14'd16, "R3 hit read", l_addr[0], 16);
    chk(l_cyc[1] - l_cyc[0] == 2, "R6 bl8 interrupt gap", l_cyc[1] - l_cyc[0], 2);
    chk(l_cmd[2] == 3'b100, "R9 write code", l_cmd[2], 4);
    chk(l_cyc[2] - l_cyc[1] == 4, "R5 bl8 mixed gap", l_cyc[2] - l_cyc[1], 4);
  endtask

  task automatic t_bl4;
    @(negedge clk) cfg_bl8 = 1'b0;
    n_log = 0;
    send(0, 13'd5, 10'd40, 1'b0, 1'b0);
    send(0, 13'd5, 10'd48, 1'b1, 1'b0);
    send(0, 13'd5, 10'd56, 1'b1, 1'b0);
    idle(12);
    chk(n_log == 3, "R5 bl4 count", n_log, 3);
    chk(l_cyc[1] - l_cyc[0] == 2, "R5 bl4 mixed gap", l_cyc[1] - l_cyc[0], 2);
    chk(l_cyc[2] - l_cyc[1] == 2, "R6 bl4 same gap", l_cyc[2] - l_cyc[1], 2);
    @(negedge clk) cfg_bl8 = 1'b1;
  endtask

  task automatic t_conflict;
    n_log = 0;
    send(0, 13'd5, 10'd0, 1'b0, 1'b0);
    send(0, 13'd9, 10'd4, 1'b0, 1'b0);
    idle(16);
    chk(n_log == 4, "R4 count", n_log, 4);
    chk(l_cmd[1] == 3'b010 && l_addr[1][10] == 1'b0, "R4 single precharge", l_cmd[1], 2);
    chk(l_cyc[1] - l_cyc[0] == 4, "R4 wait burst end", l_cyc[1] - l_cyc[0], 4);
    chk(l_cmd[2] == 3'b011 && l_addr[2] == 14'd9, "R4 act row", l_addr[2], 9);
    chk(l_cyc[2] - l_cyc[1] == TRP, "R4 trp gap", l_cyc[2] - l_cyc[1], TRP);
    chk(l_cyc[3] - l_cyc[2] == TRCD, "R4 trcd gap", l_cyc[3] - l_cyc[2], TRCD);
  endtask

  task automatic t_autopre;
    n_log = 0;
    send(1, 13'd7, 10'd2, 1'b1, 1'b1);
    send(1, 13'd7, 10'd3, 1'b1, 1'b0);
    idle(20);
    chk(n_log == 4, "R7 count no precharge", n_log, 4);
    chk(l_cmd[1] == 3'b100 && l_addr[1] == 14'h402, "R7 flag bit10", l_addr[1], 'h402);
    chk(l_cmd[2] == 3'b011 && l_bank[2] == 1, "R7 reopen with act", l_cmd[2], 3);
    chk(l_cyc[2] - l_cyc[1] == 4 + TRP, "R7 self close gap", l_cyc[2] - l_cyc[1], 4 + TRP);
    chk(l_cmd[3] == 3'b100 && l_addr[3] == 14'd3, "R7 plain write", l_addr[3], 3);
  endtask

  task automatic t_concurrent;
    n_log = 0;
    send(0, 13'd9, 10'd1, 1'b0, 1'b0);
    send(2, 13'd3, 10'd0, 1'b0, 1'b0);
    idle(12);
    chk(n_log == 3, "R8 count", n_log, 3);
    chk(l_cmd[1] == 3'b011 && l_bank[1] == 2, "R8 act other bank", l_bank[1], 2);
    chk(l_cyc[1] - l_cyc[0] == 1, "R8 act during burst", l_cyc[1] - l_cyc[0], 1);
    chk(l_cyc[2] - l_cyc[1] == TRCD, "R8 trcd gap", l_cyc[2] - l_cyc[1], TRCD);
  endtask

  task automatic t_refresh;
    n_log = 0; ack_cyc = -1;
    @(negedge clk) ref_req = 1'b1;
    #1 chk(req_ready == 1'b0, "R10 stall", req_ready, 0);
    idle(12);
    chk(n_log == 1, "R10 one precharge", n_log, 1);
    chk(l_cmd[0] == 3'b010 && l_addr[0][10] == 1'b1, "R10 all-bank flag", l_addr[0], 'h400);
    chk(ack_cyc - l_cyc[0] == TRP, "R10 ack timing", ack_cyc - l_cyc[0], TRP);
    chk(ref_ack == 1'b1, "R10 ack held", ref_ack, 1);
    @(negedge clk) ref_req = 1'b0;
    #1 chk(req_ready == 1'b1, "R10 ready again", req_ready, 1);
    idle(2);
    chk(ref_ack == 1'b0, "R10 ack drop", ref_ack, 0);
    // second refresh with every bank already closed
    n_log = 0;
    @(negedge clk) ref_req = 1'b1;
    idle(6);
    chk(n_log == 0 && ref_ack == 1'b1, "R10 direct ack", n_log, 0);
    @(negedge clk) ref_req = 1'b0;
    idle(2);
    n_log = 0;
    send(0, 13'd9, 10'd5, 1'b0, 1'b0);
    idle(10);
    chk(n_log == 2 && l_cmd[0] == 3'b011, "R10 banks closed after", l_cmd[0], 3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset;
    t_miss;
    t_hit_intr;
    t_bl4;
    t_conflict;
    t_autopre;
    t_concurrent;
    t_refresh;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule